// File: doc/BRIEF.md
# Five-Stage Move Pipeline Core

This block is a small in-order processor core with five stages: fetch, decode, execute, memory and writeback. It runs a four-instruction subset of a 64-bit teaching instruction set: halt, nop, register-to-register move and immediate-to-register move. Every instruction passes through all five stages, including the two that do no work for this subset. Pipeline registers separate each stage from the next. A further register ahead of fetch holds the program counter.

Instruction bytes come from a byte-addressed instruction store inside the block, which is written through a simple load port while the core is held in reset. Sixteen 64-bit registers make up the register file. A read-after-write dependency between back-to-back moves is resolved without stalling, by forwarding the in-flight result into the operand of the decode/execute register. When fetch sees a halt, a bad opcode or an address outside the store, it freezes the program counter. The offending instruction drains down the pipe, and the status output changes only when that instruction reaches writeback. From then on the whole core is frozen, so the cycle count it shows is exact.

Top module: `pipe_core`

## Requirements
- R1: While reset is held, the status output reads 1 (running), the cycle count reads 1 and every register reads zero.
- R2: Encodings are: halt is one byte 0x00; nop is one byte 0x10; register move is 0x20 followed by a byte with the source in bits 7:4 and the destination in bits 3:0; immediate move is 0x30, then a byte with 0xF in bits 7:4 and the destination in bits 3:0, then an 8-byte little-endian immediate. Register number 15 means "no register" and is never written.
- R3: A program that is only a halt ends with status 2 at cycle 5 and leaves every register at zero.
- R4: The status output changes only when the stopping instruction reaches writeback, and every instruction before it completes. The program nop, nop, nop, halt, nop ends at cycle 8, and the trailing nop has no effect.
- R5: An opcode byte other than the four above ends the program with status 4. A nop followed by an unknown opcode ends at cycle 6.
- R6: An instruction that starts at or beyond the end of the instruction store, or whose bytes run past that end, ends the program with status 3.
- R7: A move that reads a register written by one of the three preceding instructions gets the value of the youngest such writer, with no stall. Every program of N instructions followed by a halt ends at cycle N+5.
- R8: Once the status is not 1, the status, the cycle count and all registers stay unchanged.
- R9: The cycle count starts at 1 after reset and increases by one per clock while the status is 1.
- R10: Instructions that follow a halt in memory never change a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Write enable for the instruction store |
| ld_addr | input | $clog2(IMEM_BYTES) | Byte address written |
| ld_data | input | 8 | Byte written |
| stat_o | output | 3 | 1 running, 2 halted, 3 address error, 4 invalid opcode |
| cycle_o | output | CW | Cycle count, starting at 1 |
| regs_o | output | NREG*XLEN | Register file contents, register k at bits k*XLEN upward |

## Verification
The bench goes after chains of moves in which a register is rewritten at distances of one, two and three instructions before it is read. A core whose forwarding priority was wrong would deliver an older value, and a core without forwarding would deliver the stale register file value. Stopping programs check the exact cycle count and the final status. A core that bubbled instead of passing the abnormal instruction down, or that let a trailing instruction advance, would end early, end late or corrupt a register. Address errors at the very end of the store and writes to register 15 test the boundary handling.

// File: rtl/pipe_core.sv
module pipe_core #(
  parameter int IMEM_BYTES = 256,
  parameter int XLEN = 64,
  parameter int NREG = 16,
  parameter int CW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_en,
  input  logic [$clog2(IMEM_BYTES)-1:0] ld_addr,
  input  logic [7:0]                    ld_data,
  output logic [2:0]                    stat_o,
  output logic [CW-1:0]                 cycle_o,
  output logic [NREG*XLEN-1:0]          regs_o
);
  localparam int AW = $clog2(IMEM_BYTES);
  localparam logic [3:0] NONE = 4'hF;
  localparam logic [2:0] S_AOK = 3'd1, S_HLT = 3'd2, S_ADR = 3'd3, S_INS = 3'd4;
  localparam logic [3:0] I_HALT = 4'h0, I_NOP = 4'h1, I_RR = 4'h2, I_IR = 4'h3;

  logic [7:0] imem [IMEM_BYTES];
  always_ff @(posedge clk)
    if (ld_en) imem[ld_addr] <= ld_data;

  logic run;
  assign run = (stat_o == S_AOK);

  // fetch
  logic [XLEN-1:0] f_pc;
  logic [7:0]      fb [10];
  always_comb
    for (int k = 0; k < 10; k++) fb[k] = imem[f_pc[AW-1:0] + AW'(k)];

  logic [3:0] f_icode, f_ifun, f_len;
  logic       f_known;
  logic [2:0] f_stat;
  logic [63:0] f_imm;
  assign f_icode = fb[0][7:4];
  assign f_ifun  = fb[0][3:0];
  assign f_known = (f_ifun == 4'h0) && (f_icode <= I_IR);
  assign f_imm   = {fb[9], fb[8], fb[7], fb[6], fb[5], fb[4], fb[3], fb[2]};

  always_comb begin
    case (f_icode)
      I_RR:    f_len = 4'd2;
      I_IR:    f_len = 4'd10;
      default: f_len = 4'd1;
    endcase
    if (f_pc >= XLEN'(IMEM_BYTES))                     f_stat = S_ADR;
    else if (!f_known)                                 f_stat = S_INS;
    else if (f_pc + XLEN'(f_len) > XLEN'(IMEM_BYTES))  f_stat = S_ADR;
    else if (f_icode == I_HALT)                        f_stat = S_HLT;
    else                                               f_stat = S_AOK;
  end

  always_ff @(posedge clk)
    if (!rst_n)                        f_pc <= '0;
    else if (run && f_stat == S_AOK)   f_pc <= f_pc + XLEN'(f_len);

  // fetch -> decode
  logic [2:0]      d_stat;
  logic [3:0]      d_icode, d_ra, d_rb;
  logic [XLEN-1:0] d_valc;
  always_ff @(posedge clk)
    if (!rst_n) begin
      d_stat <= S_AOK; d_icode <= I_NOP; d_ra <= NONE; d_rb <= NONE; d_valc <= '0;
    end else if (run) begin
      d_stat  <= f_stat;
      d_icode <= f_known ? f_icode : I_NOP;
      d_ra    <= fb[1][7:4];
      d_rb    <= fb[1][3:0];
      d_valc  <= XLEN'(f_imm);
    end

  // decode with operand forwarding
  logic [2:0]      e_stat;
  logic [3:0]      e_icode, e_dst;
  logic [XLEN-1:0] e_vala, e_valc, e_vale;
  logic [2:0]      m_stat, w_stat;
  logic [3:0]      m_dst, w_dst;
  logic [XLEN-1:0] m_vale, w_vale;
  logic [XLEN-1:0] rf [NREG];

  logic [3:0]      d_src, d_dst;
  logic [XLEN-1:0] d_vala;
  assign d_src = (d_stat == S_AOK && d_icode == I_RR) ? d_ra : NONE;
  assign d_dst = (d_stat == S_AOK && (d_icode == I_RR || d_icode == I_IR)) ? d_rb : NONE;
  assign d_vala = (d_src == NONE) ? '0 :
                  (d_src == e_dst) ? e_vale :
                  (d_src == m_dst) ? m_vale :
                  (d_src == w_dst) ? w_vale : rf[d_src];

  always_ff @(posedge clk)
    if (!rst_n) begin
      e_stat <= S_AOK; e_icode <= I_NOP; e_dst <= NONE; e_vala <= '0; e_valc <= '0;
    end else if (run) begin
      e_stat <= d_stat; e_icode <= d_icode; e_dst <= d_dst; e_vala <= d_vala; e_valc <= d_valc;
    end

  // execute: the move result is either the immediate or the operand
  assign e_vale = (e_icode == I_IR) ? e_valc : e_vala;

  always_ff @(posedge clk)
    if (!rst_n) begin
      m_stat <= S_AOK; m_dst <= NONE; m_vale <= '0;
      w_stat <= S_AOK; w_dst <= NONE; w_vale <= '0;
    end else if (run) begin
      m_stat <= e_stat; m_dst <= e_dst; m_vale <= e_vale;
      w_stat <= m_stat; w_dst <= m_dst; w_vale <= m_vale;
    end

  // writeback
  always_ff @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (run && w_dst != NONE) begin
      rf[w_dst] <= w_vale;
    end

  always_ff @(posedge clk)
    if (!rst_n)   cycle_o <= CW'(1);
    else if (run) cycle_o <= cycle_o + CW'(1);

  assign stat_o = w_stat;

  for (genvar g = 0; g < NREG; g++) begin : g_regs
    assign regs_o[g*XLEN +: XLEN] = rf[g];
  end

  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o != S_AOK) |=> $stable(stat_o) && $stable(cycle_o) && $stable(regs_o));

  a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o == S_AOK) |=> (cycle_o == $past(cycle_o) + CW'(1)));

  a_r4_leave_ok_once: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stat_o) |-> ($past(stat_o) == S_AOK));

  a_r6_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_o >= S_AOK) && (stat_o <= S_INS));

  a_r7_youngest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (run && d_src != NONE && d_src == e_dst) |=> (e_vala == $past(e_vale)));

  a_r10_no_write_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (w_stat != S_AOK) |-> (w_dst == NONE));

  if (NREG > 15) begin : g_none_chk
    a_r2_none_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (regs_o[15*XLEN +: XLEN] == '0));
  end
endmodule

// File: tb/sim_pipe_core.sv
module sim_pipe_core;
  localparam int CLK_PERIOD = 10;
  localparam int MEMB = 256;
  localparam int XLEN = 64;
  localparam int NREG = 16;
  localparam int CW = 32;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 ld_en = 1'b0;
  logic [7:0]           ld_addr = '0;
  logic [7:0]           ld_data = '0;
  logic [2:0]           stat;
  logic [CW-1:0]        cyc;
  logic [NREG*XLEN-1:0] regs;

  pipe_core #(.IMEM_BYTES(MEMB), .XLEN(XLEN), .NREG(NREG), .CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .stat_o(stat), .cycle_o(cyc), .regs_o(regs));

  int checks = 0;
  int fails = 0;
  logic [7:0]  prog [MEMB];
  logic [63:0] mreg [NREG];
  int wp, nins;
  bit stopped;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic p_clear();
    for (int i = 0; i < MEMB; i++) prog[i] = 8'h00;
    for (int r = 0; r < NREG; r++) mreg[r] = '0;
    wp = 0; nins = 0; stopped = 0;
  endtask

  task automatic p_put(logic [7:0] b);
    if (wp < MEMB) prog[wp] = b;
    wp++;
  endtask

  task automatic p_nop();
    p_put(8'h10);
    if (!stopped) nins++;
  endtask

  task automatic p_halt();
    p_put(8'h00);
    stopped = 1;
  endtask

  task automatic p_rr(logic [3:0] a, logic [3:0] b);
    p_put(8'h20); p_put({a, b});
    if (!stopped) begin
      if (b != 4'hF) mreg[b] = mreg[a];
      nins++;
    end
  endtask

  task automatic p_ir(logic [3:0] b, logic [63:0] imm);
    p_put(8'h30); p_put({4'hF, b});
    for (int k = 0; k < 8; k++) p_put(imm[k*8 +: 8]);
    if (!stopped) begin
      if (b != 4'hF) mreg[b] = imm;
      nins++;
    end
  endtask

  task automatic check_regs(string tag);
    int bad = -1;
    for (int r = NREG - 1; r >= 0; r--)
      if (regs[r*XLEN +: XLEN] !== mreg[r]) bad = r;
    if (bad < 0) chk(1'b1, tag, "regs", '0, '0);
    else chk(1'b0, tag, $sformatf("reg%0d", bad), regs[bad*XLEN +: XLEN], mreg[bad]);
  endtask

  task automatic run_prog(string tag, logic [2:0] es, int ecyc);
    logic [CW-1:0] held;
    int n;
    rst_n = 1'b0;
    for (int i = 0; i < MEMB; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 8'(i); ld_data = prog[i];
    end
    @(negedge clk); ld_en = 1'b0;
    @(negedge clk);
    chk(stat == 3'd1 && cyc == 1 && regs == '0, "R1", "reset state",
        {cyc[31:0], 29'd0, stat}, {32'd1, 32'd1});
    rst_n = 1'b1;
    n = 0;
    while (stat == 3'd1 && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(stat == es, tag, "status", 64'(stat), 64'(es));
    chk(cyc == CW'(ecyc), tag, "cycles", 64'(cyc), 64'(ecyc));
    check_regs(tag);
    held = cyc;
    repeat (4) @(negedge clk);
    chk(cyc == held && stat == es, "R8", "frozen cycles", 64'(cyc), 64'(held));
    check_regs("R8");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL R9 watchdog act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7331));

    // R3: halt only
    p_clear(); p_halt();
    run_prog("R3", 3'd2, 5);

    // R4: trailing nop after halt
    p_clear(); p_nop(); p_nop(); p_nop(); p_halt(); p_nop();
    run_prog("R4", 3'd2, 8);

    // R5: unknown opcode after nop, and nonzero function field
    p_clear(); p_nop(); p_put(8'hC0); p_put(8'hF8);
    run_prog("R5", 3'd4, 6);
    p_clear(); p_put(8'h31); p_put(8'hF0);
    run_prog("R5", 3'd4, 5);

    // R7: dependency at distance one
    p_clear(); p_ir(4'd0, 64'd1); p_rr(4'd0, 4'd3); p_halt();
    run_prog("R7", 3'd2, 7);

    // R7: swap-like sequence
    p_clear(); p_ir(4'd0, 64'd5678); p_ir(4'd1, 64'd34); p_rr(4'd0, 4'd2); p_rr(4'd1, 4'd0); p_halt();
    run_prog("R7", 3'd2, 9);

    // R7: seven back-to-back moves
    p_clear();
    p_ir(4'd0, 64'h1); p_ir(4'd3, 64'h2); p_ir(4'd1, 64'h3);
    p_rr(4'd0, 4'd2); p_rr(4'd1, 4'd3); p_rr(4'd3, 4'd6); p_rr(4'd3, 4'd7); p_halt();
    run_prog("R7", 3'd2, 12);

    // R7: youngest of three writers wins
    p_clear(); p_ir(4'd0, 64'd11); p_ir(4'd0, 64'd22); p_ir(4'd0, 64'd33); p_rr(4'd0, 4'd5); p_halt();
    run_prog("R7", 3'd2, 9);

    // R2: destination 15 is never written; full 64-bit immediate byte order
    p_clear(); p_ir(4'hF, 64'hDEAD_BEEF_0123_4567); p_ir(4'd9, 64'h0102_0304_0506_0708); p_rr(4'd9, 4'hF); p_halt();
    run_prog("R2", 3'd2, 8);

    // R10: moves placed after the halt
    p_clear(); p_ir(4'd4, 64'd7); p_halt(); p_ir(4'd4, 64'd99); p_rr(4'd4, 4'd5);
    run_prog("R10", 3'd2, 6);

    // R6: instruction straddles the end of the store
    p_clear();
    for (int i = 0; i < MEMB - 1; i++) p_nop();
    p_put(8'h20);
    run_prog("R6", 3'd3, MEMB - 1 + 5);

    // R6: execution runs off the end
    p_clear();
    for (int i = 0; i < MEMB; i++) p_nop();
    run_prog("R6", 3'd3, MEMB + 5);

    // R7/R9: random move chains with dense register reuse
    for (int t = 0; t < 24; t++) begin
      int len;
      p_clear();
      len = 1 + int'($urandom_range(11));
      for (int j = 0; j < len; j++) begin
        int kind;
        logic [3:0] dst, src;
        kind = int'($urandom_range(9));
        dst = 4'($urandom_range(4));
        if (dst == 4'd4) dst = 4'hF;
        src = 4'($urandom_range(3));
        if (kind == 0) p_nop();
        else if (kind < 5) p_ir(dst, {$urandom, $urandom});
        else p_rr(src, dst);
      end
      p_halt();
      run_prog(t[0] ? "R7" : "R9", 3'd2, nins + 5);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule